// File: doc/BRIEF.md
# Serial Loss-of-Signal Detector

This block monitors a recovered serial bit stream. It samples one bit on each edge of the bit-rate clock and decides from data transitions whether the line has gone dead. Two separate rules apply. A long run with no transitions raises the loss flag. Only a burst of enough transitions inside a fixed observation frame lowers it again. While the flag is high, the receive data passed downstream is held at zero. Downstream logic therefore sees a clean, constant line instead of noise.

An active-low enable turns the transition-based detection on. An active-low optical-fault input from the optics forces the loss state whatever the line activity is. The bit clock keeps running during loss, so the frame and run counters go on working and the block can recover by itself.

Top module: `sig_loss_mon`

## Requirements
- R1: A transition is a sampled bit that differs from the bit sampled on the previous edge. The first bit after reset is compared against 0. With enN low and faultN high, lossFlag rises after the edge that samples the 129th consecutive bit with no transition (RUN_LIMIT = 128). It does not rise after only 128 such bits.
- R2: Observation frames are WIN = 128 edges long and run back to back. The first frame starts on the first edge after reset is released. On the last edge of a frame, loss is cleared if the frame held more than EDGE_MIN = 16 transitions, counting that edge. A frame with exactly 16 transitions leaves loss set.
- R3: While lossFlag is high, dataOut is 0. Otherwise dataOut equals sdIn in the same cycle.
- R4: While enN is high, lossFlag equals the inverse of faultN, whatever the internal detection state is.
- R5: While faultN is low, lossFlag is high and dataOut is 0, whatever the transition activity.
- R6: During and after a synchronous active-high reset, lossFlag is high. It stays high until the R2 clearing rule is first met.
- R7: Runs of up to 112 bits without a transition, inside frames carrying 16 transitions each, neither declare loss nor clear it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock, one serial bit per rising edge |
| rst | input | 1 | Synchronous active-high reset |
| sdIn | input | 1 | Serial receive data |
| enN | input | 1 | Active-low enable of transition-based detection |
| faultN | input | 1 | Active-low external optical-fault flag |
| lossFlag | output | 1 | Loss-of-signal indication, high while loss holds |
| dataOut | output | 1 | Receive data, forced to 0 during loss |

## Verification
The bench builds the block with its defaults: a run limit of 128, a 128-bit frame and a transition threshold of 16. With these values the exact 16-versus-17 clearing boundary and the 128-versus-129 declaring boundary can be reached within a few thousand cycles. The bench drives frames aligned to the free-running frame, each with a chosen number of toggles. This places every clearing decision on a known edge. The enable and fault overrides are then exercised against both settled internal states.

// File: rtl/sig_loss_pkg.sv
package sig_loss_pkg;

  // Strobes from the datapath to the control
  typedef struct packed {
    logic quietHit;   // one bit too many without a transition
    logic frameEnd;   // last edge of the observation frame
    logic clearHit;   // frame end with enough transitions
  } lossStat_t;

  // Strobes from the control to the datapath
  typedef struct packed {
    logic forceZero;  // hold outgoing data low
  } lossCtl_t;

endpackage

// File: rtl/sig_loss_dp.sv
module sig_loss_dp
  import sig_loss_pkg::*;
#(
  parameter int RUN_LIMIT = 128,
  parameter int WIN       = 128,
  parameter int EDGE_MIN  = 16
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      sdIn,
  input  lossCtl_t  ctl,
  output lossStat_t stat,
  output logic      dataOut
);

  localparam int QW = $clog2(RUN_LIMIT + 1);
  localparam int FW = (WIN > 2) ? $clog2(WIN) : 1;
  localparam int EW = $clog2(WIN + 1);

  logic          prevBit;
  logic          edgeNow;
  logic [QW-1:0] quietCnt;
  logic [FW-1:0] frameCnt;
  logic [EW-1:0] edgeCnt;
  logic [EW-1:0] edgeTotal;

  assign edgeNow   = sdIn ^ prevBit;
  assign edgeTotal = edgeCnt + EW'(edgeNow);

  assign stat.frameEnd = (frameCnt == FW'(WIN - 1));
  assign stat.quietHit = !edgeNow && (quietCnt == QW'(RUN_LIMIT));
  assign stat.clearHit = stat.frameEnd && (edgeTotal > EW'(EDGE_MIN));

  always_ff @(posedge clk) begin
    if (rst) begin
      prevBit  <= 1'b0;
      quietCnt <= '0;
      frameCnt <= '0;
      edgeCnt  <= '0;
    end else begin
      prevBit <= sdIn;
      if (edgeNow)
        quietCnt <= '0;
      else if (quietCnt != QW'(RUN_LIMIT))
        quietCnt <= quietCnt + QW'(1);
      if (stat.frameEnd) begin
        frameCnt <= '0;
        edgeCnt  <= '0;
      end else begin
        frameCnt <= frameCnt + FW'(1);
        edgeCnt  <= edgeTotal;
      end
    end
  end

  assign dataOut = ctl.forceZero ? 1'b0 : sdIn;

  // R2
  frame_gap_chk: assert property (@(posedge clk) disable iff (rst)
    stat.frameEnd |=> !stat.frameEnd);

  // R7
  quiet_bound_chk: assert property (@(posedge clk) disable iff (rst)
    quietCnt <= QW'(RUN_LIMIT));

endmodule

// File: rtl/sig_loss_ctrl.sv
module sig_loss_ctrl
  import sig_loss_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      enN,
  input  logic      faultN,
  input  lossStat_t stat,
  output lossCtl_t  ctl,
  output logic      lossFlag
);

  logic lossInt;

  always_ff @(posedge clk) begin
    if (rst)
      lossInt <= 1'b1;
    else if (stat.quietHit)
      lossInt <= 1'b1;
    else if (stat.clearHit)
      lossInt <= 1'b0;
  end

  assign lossFlag      = !faultN || (!enN && lossInt);
  assign ctl.forceZero = lossFlag;

  // R1
  declare_chk: assert property (@(posedge clk) disable iff (rst)
    stat.quietHit |=> lossInt);

  // R2
  clear_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(lossInt) |-> $past(stat.clearHit));

  // R6
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!stat.quietHit && !stat.clearHit) |=> $stable(lossInt));

endmodule

// File: rtl/sig_loss_mon.sv
module sig_loss_mon
  import sig_loss_pkg::*;
#(
  parameter int RUN_LIMIT = 128,
  parameter int WIN       = 128,
  parameter int EDGE_MIN  = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic sdIn,
  input  logic enN,
  input  logic faultN,
  output logic lossFlag,
  output logic dataOut
);

  lossStat_t stat;
  lossCtl_t  ctl;

  sig_loss_dp #(
    .RUN_LIMIT (RUN_LIMIT),
    .WIN       (WIN),
    .EDGE_MIN  (EDGE_MIN)
  ) u_dp (
    .clk     (clk),
    .rst     (rst),
    .sdIn    (sdIn),
    .ctl     (ctl),
    .stat    (stat),
    .dataOut (dataOut)
  );

  sig_loss_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .enN      (enN),
    .faultN   (faultN),
    .stat     (stat),
    .ctl      (ctl),
    .lossFlag (lossFlag)
  );

  // R3
  gate_chk: assert property (@(posedge clk) disable iff (rst)
    lossFlag |-> !dataOut);

  // R5
  fault_chk: assert property (@(posedge clk) disable iff (rst)
    !faultN |-> !dataOut);

  // R4
  pass_chk: assert property (@(posedge clk) disable iff (rst)
    (enN && faultN) |-> (dataOut == sdIn));

endmodule

// File: tb/sig_loss_mon_bench.sv
`timescale 1ns/1ps
module sig_loss_mon_bench;

  localparam int WIN  = 128;
  localparam int NSEG = 5;
  // per segment: toggles per frame, frame count, expected flag afterwards
  localparam int SEG_EDGES [NSEG] = '{17, 16, 0, 16, 17};
  localparam int SEG_WINS  [NSEG] = '{1, 2, 1, 2, 1};
  localparam int SEG_EXP   [NSEG] = '{0, 0, 1, 1, 0};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sdIn = 1'b0;
  logic enN = 1'b0;
  logic faultN = 1'b1;
  logic lossFlag;
  logic dataOut;
  logic curBit = 1'b0;
  int   nChecks = 0;
  int   nFail = 0;

  always #2 clk = ~clk;

  sig_loss_mon u_sig_loss_mon (
    .clk      (clk),
    .rst      (rst),
    .sdIn     (sdIn),
    .enN      (enN),
    .faultN   (faultN),
    .lossFlag (lossFlag),
    .dataOut  (dataOut)
  );

  task automatic check(input string req, input string what, input logic act, input logic exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
    end
  endtask

  task automatic driveBit(input logic b);
    curBit = b;
    sdIn   = b;
    @(negedge clk);
  endtask

  task automatic driveFrame(input int toggles);
    for (int i = 0; i < WIN; i++) begin
      if (i < toggles) driveBit(~curBit);
      else             driveBit(curBit);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    sdIn = 1'b1;
    repeat (3) @(negedge clk);
    // R6 reset state with a high data bit present
    check("R6", "flag in reset", lossFlag, 1'b1);
    check("R3", "data gated in reset", dataOut, 1'b0);
    sdIn   = 1'b0;
    curBit = 1'b0;
    rst    = 1'b0;

    // Frame-aligned table: R2, R6, R7, R1
    for (int s = 0; s < NSEG; s++) begin
      for (int w = 0; w < SEG_WINS[s]; w++) driveFrame(SEG_EDGES[s]);
      check(SEG_EDGES[s] == 0 ? "R1" : (SEG_EDGES[s] > 16 ? "R2" : "R7"),
            "flag at frame end", lossFlag, SEG_EXP[s] != 0);
      check("R3", "data at frame end", dataOut, (SEG_EXP[s] != 0) ? 1'b0 : sdIn);
    end

    // R5 external fault forces loss while toggling
    faultN = 1'b0;
    for (int i = 0; i < 9; i++) driveBit(~curBit);
    driveBit(1'b1);
    check("R5", "flag with fault", lossFlag, 1'b1);
    check("R5", "data with fault", dataOut, 1'b0);
    faultN = 1'b1;
    #1;
    check("R5", "flag after fault release", lossFlag, 1'b0);
    check("R3", "data passes when clear", dataOut, 1'b1);
    @(negedge clk);

    // R1 exact 129-bit boundary
    driveBit(1'b0);
    driveBit(1'b1);
    for (int i = 0; i < 128; i++) driveBit(1'b1);
    check("R1", "flag after 128 quiet bits", lossFlag, 1'b0);
    driveBit(1'b1);
    check("R1", "flag after 129 quiet bits", lossFlag, 1'b1);
    check("R3", "data gated during loss", dataOut, 1'b0);

    // R4 disable overrides internal loss
    enN = 1'b1;
    #1;
    check("R4", "flag with detection off", lossFlag, 1'b0);
    check("R4", "data with detection off", dataOut, 1'b1);
    faultN = 1'b0;
    #1;
    check("R4", "flag follows fault when off", lossFlag, 1'b1);
    faultN = 1'b1;
    enN    = 1'b0;
    #1;
    check("R6", "loss kept after enable returns", lossFlag, 1'b1);

    // R6 reset from the clear state
    @(negedge clk);
    driveFrame(17);
    driveFrame(17);
    check("R2", "cleared before reset", lossFlag, 1'b0);
    rst = 1'b1;
    @(negedge clk);
    check("R6", "flag after mid-run reset", lossFlag, 1'b1);
    rst = 1'b0;

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

endmodule